// File: doc/BRIEF.md
# Range Data Watchpoint Unit

The unit sits beside a processor's load/store port and compares each data access with six address-range watchpoints. Every slot holds an inclusive lower and upper bound and is armed for reads, writes or both by a 2-bit field packed into a shared control word. An access can match only while a global enable bit is set. When an access qualifies, the unit raises a one-cycle debug request, loads an exception status word with a fixed cause code and the slot index, and captures the data address of the access.

Debugger software programs the unit through a small word-wide register port. It arms a slot by writing its bounds and its trigger field. It disarms a slot by clearing the field and zeroing both bounds. Clearing a slot leaves the global enable alone.

Top module: `dwatch_unit`

## Requirements
- R1: While reset is held, and after reset, `dbg_req` is 0 and every register (control, mode, status, fault address, all bounds) reads 0.
- R2: Register map by `reg_addr`: 0 control word, 1 mode word, 2 exception status, 3 fault address, 8+2n lower bound of slot n, 9+2n upper bound of slot n. Each of these reads back the last value written. Any other address reads 0.
- R3: Slot n's trigger field sits in control bits [3+4n:2+4n]. 01 arms the slot for reads (`acc_rd`), 10 for writes (`acc_wr`), 11 for both, and 00 disables it.
- R4: A slot matches when lower <= `acc_addr` <= upper, compared unsigned. Both bounds are included, and lower-1 and upper+1 do not match.
- R5: No slot fires unless mode bit 19 (global enable) is 1.
- R6: A qualifying access sampled at a clock edge makes `dbg_req` 1 for the following cycle only. It returns to 0 unless another access qualifies.
- R7: On a hit, the exception status becomes cause 0x0C in bits 15:8 and the slot index in bits 2:0, with all other bits 0. `hit_slot` equals status bits 2:0.
- R8: On a hit, `fault_addr` captures `acc_addr` of the triggering access.
- R9: When several slots match in one cycle, a single hit is reported, carrying the lowest matching slot index.
- R10: Status and fault address hold their values until a software write or a new hit. A hit in the same cycle as a software write to them wins.
- R11: A slot disarmed to field 00 with zero bounds never fires, including for accesses to address 0.
- R12: Accesses with `acc_valid` low, or with neither `acc_rd` nor `acc_wr` set, never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_valid | input | 1 | Data access valid |
| acc_rd | input | 1 | Access is a read |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 32 | Access data address |
| dbg_req | output | 1 | One-cycle debug exception request |
| hit_slot | output | 3 | Index of the slot behind the last hit |
| exc_status | output | 32 | Exception status word |
| fault_addr | output | 32 | Captured data address |

## Verification
The properties assume that each access is held on the port for exactly one clock. They also assume that `acc_addr` is stable across the edge that samples it, so that a request can be traced to the access one cycle earlier. The stimulus drives every access at a falling edge and withdraws it at the next falling edge. Random bounds are kept inside a narrow address window so that hits, misses, overlaps and bound edges all occur. Directed cases cover the top of the address space, the disabled and disarmed states, and a hit that collides with a software write to the status word.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  localparam int DATA_W        = 32;
  localparam int FIELD_LSB     = 2;
  localparam int FIELD_STRIDE  = 4;
  localparam int GEN_BIT       = 19;
  localparam int CAUSE_LSB     = 8;
  localparam logic [7:0] CAUSE_CODE = 8'h0C;
  localparam int REG_CTRL      = 0;
  localparam int REG_MODE      = 1;
  localparam int REG_STAT      = 2;
  localparam int REG_FADDR     = 3;
  localparam int REG_SLOT_BASE = 8;

  typedef enum logic [1:0] {
    TRIG_OFF = 2'b00,
    TRIG_RD  = 2'b01,
    TRIG_WR  = 2'b10,
    TRIG_RW  = 2'b11
  } trig_e;
endpackage

// File: rtl/dwu_slot_cmp.sv
module dwu_slot_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        trig,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              rd,
  input  logic              wr,
  input  logic              gen_en,
  output logic              match
);
  logic dir_ok;
  logic in_range;

  always_comb begin
    dir_ok   = (trig[0] & rd) | (trig[1] & wr);
    in_range = (addr >= lo) && (addr <= hi);
    match    = valid & gen_en & dir_ok & in_range;
  end
endmodule

// File: rtl/dwu_prio_enc.sv
module dwu_prio_enc #(
  parameter int N = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dwu_regfile.sv
module dwu_regfile
  import dwu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 6,
  parameter int REG_AW    = 5,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [REG_AW-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [DATA_W-1:0]                  rdata,
  input  logic                               hit,
  input  logic [SLOT_W-1:0]                  hit_idx,
  input  logic [ADDR_W-1:0]                  hit_addr,
  output logic [DATA_W-1:0]                  ctrl,
  output logic                               gen_en,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   lo,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   hi,
  output logic [DATA_W-1:0]                  stat,
  output logic [ADDR_W-1:0]                  faddr
);
  logic [DATA_W-1:0] ctrl_q, mode_q, stat_q, stat_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] lo_q, hi_q;
  logic ctrl_en, mode_en, stat_en, faddr_en;
  logic [NUM_SLOTS-1:0] lo_en, hi_en;

  // next-state and enables
  always_comb begin
    ctrl_en  = we && (addr == REG_AW'(REG_CTRL));
    mode_en  = we && (addr == REG_AW'(REG_MODE));
    stat_en  = hit || (we && (addr == REG_AW'(REG_STAT)));
    faddr_en = hit || (we && (addr == REG_AW'(REG_FADDR)));
    for (int n = 0; n < NUM_SLOTS; n++) begin
      lo_en[n] = we && (addr == REG_AW'(REG_SLOT_BASE + 2 * n));
      hi_en[n] = we && (addr == REG_AW'(REG_SLOT_BASE + 2 * n + 1));
    end
    if (hit) begin
      stat_d = '0;
      stat_d[CAUSE_LSB +: 8] = CAUSE_CODE;
      stat_d[SLOT_W-1:0]     = hit_idx;
      faddr_d = hit_addr;
    end else begin
      stat_d  = wdata;
      faddr_d = wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      stat_q  <= '0;
      faddr_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= wdata;
      if (mode_en)  mode_q  <= wdata;
      if (stat_en)  stat_q  <= stat_d;
      if (faddr_en) faddr_q <= faddr_d;
      for (int n = 0; n < NUM_SLOTS; n++) begin
        if (lo_en[n]) lo_q[n] <= wdata[ADDR_W-1:0];
        if (hi_en[n]) hi_q[n] <= wdata[ADDR_W-1:0];
      end
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == REG_AW'(REG_CTRL))  rdata = ctrl_q;
    if (addr == REG_AW'(REG_MODE))  rdata = mode_q;
    if (addr == REG_AW'(REG_STAT))  rdata = stat_q;
    if (addr == REG_AW'(REG_FADDR)) rdata = DATA_W'(faddr_q);
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (addr == REG_AW'(REG_SLOT_BASE + 2 * n))     rdata = DATA_W'(lo_q[n]);
      if (addr == REG_AW'(REG_SLOT_BASE + 2 * n + 1)) rdata = DATA_W'(hi_q[n]);
    end
  end

  assign ctrl   = ctrl_q;
  assign gen_en = mode_q[GEN_BIT];
  assign lo     = lo_q;
  assign hi     = hi_q;
  assign stat   = stat_q;
  assign faddr  = faddr_q;
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 6,
  localparam int REG_AW   = $clog2(REG_SLOT_BASE + 2 * NUM_SLOTS),
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              dbg_req,
  output logic [SLOT_W-1:0] hit_slot,
  output logic [DATA_W-1:0] exc_status,
  output logic [ADDR_W-1:0] fault_addr
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [DATA_W-1:0] ctrl;
  logic       gen_en;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] lo, hi;
  logic [NUM_SLOTS-1:0] slot_match;
  logic       hit_any;
  logic [SLOT_W-1:0] hit_idx;
  logic       req_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dwu_regfile #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .hit(hit_any), .hit_idx(hit_idx), .hit_addr(acc_addr),
    .ctrl(ctrl), .gen_en(gen_en), .lo(lo), .hi(hi),
    .stat(exc_status), .faddr(fault_addr)
  );

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    dwu_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .trig(ctrl[FIELD_LSB + FIELD_STRIDE * n +: 2]),
      .lo(lo[n]), .hi(hi[n]), .addr(acc_addr),
      .valid(acc_valid), .rd(acc_rd), .wr(acc_wr), .gen_en(gen_en),
      .match(slot_match[n])
    );
  end

  dwu_prio_enc #(.N(NUM_SLOTS)) u_prio (
    .req(slot_match), .any(hit_any), .idx(hit_idx)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) req_q <= 1'b0;
    else            req_q <= hit_any;
  end

  assign dbg_req  = req_q;
  assign hit_slot = exc_status[SLOT_W-1:0];
endmodule

// File: rtl/dwatch_unit_chk.sv
module dwatch_unit_chk
  import dwu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 6,
  parameter int REG_AW    = 5,
  parameter int SLOT_W    = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              acc_valid,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              gen_en,
  input logic              dbg_req,
  input logic [SLOT_W-1:0] hit_slot,
  input logic [DATA_W-1:0] exc_status,
  input logic [ADDR_W-1:0] fault_addr
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!dbg_req && exc_status == '0 && fault_addr == '0));

  a_r12_req_needs_access: assert property (@(posedge clk) disable iff (!rst_int_n)
    dbg_req |-> $past(acc_valid && (acc_rd || acc_wr)));

  a_r5_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_int_n)
    dbg_req |-> $past(gen_en));

  a_r7_cause_loaded: assert property (@(posedge clk) disable iff (!rst_int_n)
    dbg_req |-> (exc_status[CAUSE_LSB +: 8] == CAUSE_CODE
                 && int'(hit_slot) < NUM_SLOTS));

  a_r8_addr_captured: assert property (@(posedge clk) disable iff (!rst_int_n)
    dbg_req |-> fault_addr == $past(acc_addr));

  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!dbg_req && !$past(reg_we && reg_addr == REG_AW'(REG_STAT)))
      |-> $stable(exc_status));
endmodule

bind dwatch_unit dwatch_unit_chk #(
  .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .acc_valid(acc_valid), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .gen_en(gen_en), .dbg_req(dbg_req), .hit_slot(hit_slot),
  .exc_status(exc_status), .fault_addr(fault_addr)
);

// File: tb/dwatch_unit_test.sv
`timescale 1ns/1ps
module dwatch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        dbg_req;
  logic [2:0]  hit_slot;
  logic [31:0] exc_status, fault_addr;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [31:0] sh_ctrl = '0, sh_mode = '0, sh_stat = '0, sh_fa = '0;
  logic [31:0] sh_lo [6];
  logic [31:0] sh_hi [6];

  always #2.5 clk = ~clk;

  dwatch_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr), .dbg_req(dbg_req),
    .hit_slot(hit_slot), .exc_status(exc_status), .fault_addr(fault_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_slot(input logic [31:0] a, input logic rd, input logic wr);
    if (!sh_mode[19]) return -1;
    for (int n = 0; n < 6; n++) begin
      logic [1:0] f;
      f = sh_ctrl[2 + 4 * n +: 2];
      if (((f[0] && rd) || (f[1] && wr)) && a >= sh_lo[n] && a <= sh_hi[n]) return n;
    end
    return -1;
  endfunction

  function automatic logic [31:0] stat_word(input int s);
    return {16'h0, 8'h0C, 5'b0, 3'(s)};
  endfunction

  task automatic shadow_write(input logic [4:0] a, input logic [31:0] d);
    case (a)
      5'd0: sh_ctrl = d;
      5'd1: sh_mode = d;
      5'd2: sh_stat = d;
      5'd3: sh_fa   = d;
      default: if (a >= 8 && a < 20) begin
        if (a[0]) sh_hi[(a - 8) / 2] = d; else sh_lo[(a - 8) / 2] = d;
      end
    endcase
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    shadow_write(a, d);
  endtask

  task automatic rd_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic set_slot(input int n, input logic [1:0] f, input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] c;
    c = sh_ctrl;
    c[2 + 4 * n +: 2] = f;
    wr_reg(5'(8 + 2 * n), lo);
    wr_reg(5'(9 + 2 * n), hi);
    wr_reg(5'd0, c);
  endtask

  task automatic access(input logic [31:0] a, input logic rd, input logic wr,
                        input logic v, input string tag);
    int s;
    @(negedge clk);
    check({tag, " R6 idle before access"}, {31'b0, dbg_req}, 32'd0);
    acc_valid = v; acc_rd = rd; acc_wr = wr; acc_addr = a;
    s = v ? exp_slot(a, rd, wr) : -1;
    @(negedge clk);
    acc_valid = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
    if (s >= 0) begin
      sh_stat = stat_word(s);
      sh_fa = a;
    end
    check({tag, " req"}, {31'b0, dbg_req}, (s >= 0) ? 32'd1 : 32'd0);
    check({tag, " R7 status"}, exc_status, sh_stat);
    check({tag, " R7 hit_slot"}, {29'b0, hit_slot}, {29'b0, sh_stat[2:0]});
    check({tag, " R8 fault_addr"}, fault_addr, sh_fa);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int n = 0; n < 6; n++) begin sh_lo[n] = '0; sh_hi[n] = '0; end
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req in reset", {31'b0, dbg_req}, 32'd0);
    check("R1 status in reset", exc_status, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_check(5'd0, 32'd0, "R1 ctrl after reset");
    rd_check(5'd1, 32'd0, "R1 mode after reset");
    rd_check(5'd3, 32'd0, "R1 fault after reset");
    rd_check(5'd19, 32'd0, "R1 slot5 upper after reset");

    // R2 register map
    for (int a = 0; a < 20; a++) begin
      if (a < 4 || a >= 8) wr_reg(5'(a), 32'hA500_0000 + 32'(a));
    end
    for (int a = 0; a < 24; a++)
      rd_check(5'(a), (a < 4 || (a >= 8 && a < 20)) ? 32'hA500_0000 + 32'(a) : 32'd0,
               $sformatf("R2 readback %0d", a));
    for (int a = 0; a < 20; a++) if (a < 4 || a >= 8) wr_reg(5'(a), 32'd0);

    // R11 disarmed slots, enable on
    wr_reg(5'd1, 32'h0008_0000);
    access(32'd0, 1, 0, 1, "R11 rd at 0 disarmed");
    access(32'd0, 0, 1, 1, "R11 wr at 0 disarmed");

    // R3 trigger encodings on slot 2
    set_slot(2, 2'b01, 32'h100, 32'h1FF);
    access(32'h150, 1, 0, 1, "R3 rd field rd");
    access(32'h150, 0, 1, 1, "R3 rd field wr");
    set_slot(2, 2'b10, 32'h100, 32'h1FF);
    access(32'h150, 1, 0, 1, "R3 wr field rd");
    access(32'h150, 0, 1, 1, "R3 wr field wr");
    set_slot(2, 2'b11, 32'h100, 32'h1FF);
    access(32'h151, 1, 0, 1, "R3 rw field rd");
    access(32'h152, 0, 1, 1, "R3 rw field wr");

    // R4 bounds
    access(32'h100, 1, 0, 1, "R4 lower bound");
    access(32'h1FF, 1, 0, 1, "R4 upper bound");
    access(32'h0FF, 1, 0, 1, "R4 below");
    access(32'h200, 1, 0, 1, "R4 above");
    set_slot(5, 2'b11, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
    access(32'hFFFF_FFFF, 0, 1, 1, "R4 top of space");
    access(32'h8000_0000, 0, 1, 1, "R4 unsigned compare");

    // R12 invalid or directionless
    access(32'h150, 1, 1, 0, "R12 valid low");
    access(32'h150, 0, 0, 1, "R12 no direction");

    // R9 overlap: slots 1 and 4
    set_slot(4, 2'b11, 32'h180, 32'h2FF);
    set_slot(1, 2'b01, 32'h1F0, 32'h300);
    access(32'h1F8, 1, 0, 1, "R9 slots 1 2 4 overlap");
    access(32'h250, 1, 0, 1, "R9 slots 1 4 overlap");
    access(32'h250, 0, 1, 1, "R9 only 4 for write");

    // R10 hold, software write, collision
    repeat (3) @(negedge clk);
    check("R10 status holds", exc_status, sh_stat);
    check("R10 fault holds", fault_addr, sh_fa);
    wr_reg(5'd2, 32'h0000_0055);
    check("R10 sw write status", exc_status, 32'h0000_0055);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd2; reg_wdata = 32'h0000_0077;
    acc_valid = 1'b1; acc_rd = 1'b1; acc_addr = 32'h120;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0; acc_rd = 1'b0;
    sh_stat = stat_word(2); sh_fa = 32'h120;
    check("R10 hit beats write", exc_status, stat_word(2));
    check("R6 collision req", {31'b0, dbg_req}, 32'd1);
    @(negedge clk);
    check("R6 pulse ends", {31'b0, dbg_req}, 32'd0);

    // R5 enable off; disarm keeps enable
    wr_reg(5'd1, 32'h0000_0000);
    access(32'h150, 1, 1, 1, "R5 enable off");
    wr_reg(5'd1, 32'h0008_0000);
    set_slot(2, 2'b00, 32'h0, 32'h0);
    rd_check(5'd1, 32'h0008_0000, "R11 disarm keeps enable");
    access(32'h0, 1, 1, 1, "R11 slot2 cleared at 0");
    access(32'h1F8, 1, 0, 1, "R9 after slot2 cleared");

    // random mix
    for (int it = 0; it < 300; it++) begin
      if (it % 25 == 0) begin
        for (int n = 0; n < 6; n++) begin
          logic [31:0] lo;
          lo = $urandom % 1024;
          set_slot(n, 2'($urandom % 4), lo, lo + ($urandom % 64));
        end
        wr_reg(5'd1, ($urandom % 6 != 0) ? 32'h0008_0000 : 32'h0);
      end
      access($urandom % 1100, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
             "R3 R4 R9 random");
    end
    finish_run();
  end
endmodule